// File: doc/BRIEF.md
# I2C Slave Register Port With 16-bit Registers

This block is the slave side of a two-wire I2C-compatible bus. It gives a master access to a bank of 16-bit registers with 10-bit addresses. A fast system clock oversamples SCL and SDA. The block detects start, repeated start and stop conditions and answers to one fixed 7-bit device address. In a write, it takes a two-byte register pointer and then turns each following pair of bytes into one 16-bit register write. In a read, it returns the high byte and then the low byte of each register. The pointer moves forward after each whole register.

The register storage is outside the block. It is reached through a synchronous port: `reg_addr_o` always shows the pointer, a one-cycle `reg_we_o` strobe writes `reg_wdata_o`, and `reg_rdata_i` must show the addressed register no later than the clock after the address changes. The block pulls SDA low by raising `sda_oe_o`. Outside the block, the pad drives low while it is set and floats otherwise.

Top module: `i2c_reg_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) or a stop (SDA rises while SCL is high) takes effect at any point, including in the middle of a byte. A stop in the middle of a byte causes no register write.
- R2: The first byte after a start carries the device address in bits 7..1, MSB first, and the direction in bit 0 (0 = write, 1 = read). The default device address is binary 0101110.
- R3: On an address match the slave holds SDA low for the ninth SCL pulse (ACK). On a mismatch it leaves SDA released and ignores the bus until the next start.
- R4: In a write, the first two data bytes set the pointer to {first[1:0], second[7:0]}. Bits 7..2 of the first byte have no effect.
- R5: Each later pair of write bytes (high byte first) produces one single-cycle write of {high, low} to the pointed register. The pointer then increments by one.
- R6: A write to the last address (parameter, default 10'h3FF) is performed, after which the pointer stays there. Every later write pair in the transfer is discarded.
- R7: A read sends the pointed register's bits 15..8, then bits 7..0, MSB first. After a low byte that the master ACKs, the pointer advances.
- R8: When a read reaches the last address, every further register read returns that register again.
- R9: A stop clears the pointer to 0. A repeated start keeps it, so a write that only sets the pointer can be followed by a read.
- R10: After the master NACKs a read byte, the slave drives SDA no more until the next start.
- R11: A trailing write byte without a partner is never written.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the SCL rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| reg_addr_o | output | AW | Current register pointer |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 16 | Data for the register write |
| reg_rdata_i | input | 16 | Register contents at `reg_addr_o` |

## Verification
The assertions watch, on every cycle, that SDA is only driven or released while SCL is low, that each write strobe lasts one cycle and moves the pointer up by one, and that the pointer holds at the last address. The bench's bus transfers are the only way to show the byte-level behaviour: address matching and ACKs, how the pointer is built and where it saturates, the high/low byte order, the pointer clear on stop against the pointer kept on a repeated start, dropped odd bytes, the silence after a NACK, and an abort in the middle of a byte.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned BW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [2:0] scl_q, sda_q;

  // bits 0..1 synchronize, bit 2 is the previous level for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_o     = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  assign sda_o      = sda_q[1];
endmodule

// File: rtl/i2c_reg_core.sv
module i2c_reg_core
  import i2c_reg_pkg::*;
#(
  parameter int unsigned    AW       = 10,
  parameter logic [AW-1:0]  MAX_ADDR = '1,
  parameter logic [6:0]     DEV_ADDR = 7'b0101110
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o
);
  localparam int unsigned HW = AW - BW;

  state_e          state_q;
  logic [3:0]      bit_cnt_q;
  logic [BW-1:0]   sr_q, tx_q;
  logic            ack_on_q, rw_q, rd_lo_q, full_q;
  logic [1:0]      byte_idx_q;
  logic [HW-1:0]   ptr_hi_q;
  logic [BW-1:0]   data_hi_q;
  logic [AW-1:0]   ptr_q;
  logic [BW-1:0]   nxt_byte, byte_sel;

  assign nxt_byte = {sr_q[BW-2:0], sda_i};
  assign byte_sel = rd_lo_q ? rdata_i[BW-1:0] : rdata_i[DW-1:BW];
  assign addr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      sr_q       <= '0;
      tx_q       <= '0;
      ack_on_q   <= 1'b0;
      rw_q       <= 1'b0;
      rd_lo_q    <= 1'b0;
      full_q     <= 1'b0;
      byte_idx_q <= '0;
      ptr_hi_q   <= '0;
      data_hi_q  <= '0;
      ptr_q      <= '0;
      sda_oe_o   <= 1'b0;
      we_o       <= 1'b0;
      wdata_o    <= '0;
    end else begin
      we_o <= 1'b0;
      // pointer step after a register write, saturating at the top
      if (we_o) begin
        if (ptr_q == MAX_ADDR) full_q <= 1'b1;
        else                   ptr_q  <= ptr_q + 1'b1;
      end
      if (stop_i) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ptr_q    <= '0;
        full_q   <= 1'b0;
      end else if (start_i) begin
        state_q    <= ST_ADDR;
        bit_cnt_q  <= '0;
        sda_oe_o   <= 1'b0;
        byte_idx_q <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR: if (scl_rise_i) begin
            sr_q <= nxt_byte;
            if (bit_cnt_q == 4'd7) begin
              bit_cnt_q <= '0;
              if (nxt_byte[BW-1:1] == DEV_ADDR) begin
                rw_q     <= nxt_byte[0];
                rd_lo_q  <= 1'b0;
                ack_on_q <= 1'b0;
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            if (!ack_on_q) begin
              sda_oe_o <= 1'b1;
              ack_on_q <= 1'b1;
            end else if (rw_q) begin
              tx_q      <= byte_sel;
              sda_oe_o  <= ~byte_sel[BW-1];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end else begin
              sda_oe_o  <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RX;
            end
          end
          ST_RX: if (scl_rise_i) begin
            sr_q <= nxt_byte;
            if (bit_cnt_q == 4'd7) begin
              bit_cnt_q <= '0;
              ack_on_q  <= 1'b0;
              state_q   <= ST_RX_ACK;
              unique case (byte_idx_q)
                2'd0: begin
                  ptr_hi_q   <= nxt_byte[HW-1:0];
                  byte_idx_q <= 2'd1;
                end
                2'd1: begin
                  ptr_q      <= {ptr_hi_q, nxt_byte};
                  full_q     <= 1'b0;
                  byte_idx_q <= 2'd2;
                end
                2'd2: begin
                  data_hi_q  <= nxt_byte;
                  byte_idx_q <= 2'd3;
                end
                default: begin
                  if (!full_q) begin
                    we_o    <= 1'b1;
                    wdata_o <= {data_hi_q, nxt_byte};
                  end
                  byte_idx_q <= 2'd2;
                end
              endcase
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
          ST_RX_ACK: if (scl_fall_i) begin
            if (!ack_on_q) begin
              sda_oe_o <= 1'b1;
              ack_on_q <= 1'b1;
            end else begin
              sda_oe_o <= 1'b0;
              state_q  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise_i) bit_cnt_q <= bit_cnt_q + 1'b1;
            if (scl_fall_i) begin
              if (bit_cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= ST_TX_ACK;
              end else begin
                sda_oe_o <= ~tx_q[BW-2];
                tx_q     <= {tx_q[BW-2:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              if (sda_i) begin
                state_q <= ST_IDLE;  // master NACK
              end else if (rd_lo_q) begin
                rd_lo_q <= 1'b0;
                if (ptr_q != MAX_ADDR) ptr_q <= ptr_q + 1'b1;
              end else begin
                rd_lo_q <= 1'b1;
              end
            end
            if (scl_fall_i) begin
              tx_q      <= byte_sel;
              sda_oe_o  <= ~byte_sel[BW-1];
              bit_cnt_q <= '0;
              state_q   <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_reg_pkg::*;
#(
  parameter int unsigned    AW       = 10,
  parameter logic [AW-1:0]  MAX_ADDR = '1,
  parameter logic [6:0]     DEV_ADDR = 7'b0101110
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic scl_rise, scl_fall, start, stop, sda_s;

  i2c_line_sync u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop),
    .sda_o      (sda_s)
  );

  i2c_reg_core #(
    .AW       (AW),
    .MAX_ADDR (MAX_ADDR),
    .DEV_ADDR (DEV_ADDR)
  ) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .sda_i      (sda_s),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .addr_o     (reg_addr_o),
    .we_o       (reg_we_o),
    .wdata_o    (reg_wdata_o)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int unsigned   AW       = 10,
  parameter logic [AW-1:0] MAX_ADDR = '1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_i,
  input logic          sda_oe_o,
  input logic          reg_we_o,
  input logic [AW-1:0] reg_addr_o
);
  // R12
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o != MAX_ADDR) |=> reg_addr_o == AW'($past(reg_addr_o) + 1'b1));

  // R6
  ptr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_addr_o == MAX_ADDR) |=> reg_addr_o == MAX_ADDR);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.AW(AW), .MAX_ADDR(MAX_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .reg_we_o   (reg_we_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int H = 8;
  localparam logic [6:0] DEV = 7'b0101110;
  localparam logic [25:0] VEC [6] = '{
    {10'h001, 16'h1234}, {10'h155, 16'hABCD}, {10'h2AA, 16'h0F0F},
    {10'h3FD, 16'hFFFF}, {10'h100, 16'h0000}, {10'h0FF, 16'h8001}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, we;
  logic [9:0] addr;
  logic [15:0] wdata, rdata;
  logic [15:0] mem [1024];
  logic [15:0] rd_buf [4];
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_err = 0, r12_viol = 0;

  always #2.5 clk = ~clk;

  i2c_reg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(addr), .reg_we_o(we),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata));

  function automatic logic [15:0] init_val(input int i);
    return 16'((i * 37) ^ 16'hA5C3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
    end else begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end

  always @(sda_oe) if (scl_m && rst_n) r12_viol++;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hb; repeat (H) @(negedge clk); endtask
  task automatic i2c_start; sda_m = 1; hb; scl_m = 1; hb; sda_m = 0; hb; scl_m = 0; hb; endtask
  task automatic i2c_stop; sda_m = 0; hb; scl_m = 1; hb; sda_m = 1; hb; endtask
  task automatic send_bit(input logic b); sda_m = b; hb; scl_m = 1; hb; hb; scl_m = 0; hb; endtask
  task automatic recv_bit(output logic b);
    sda_m = 1; hb; scl_m = 1; hb; b = sda_line; hb; scl_m = 0; hb;
  endtask
  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic bit_v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(bit_v);
    ack = !bit_v;
  endtask
  task automatic read_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
    send_bit(!mack);
  endtask

  // pointer bytes with junk in upper bits 7..2 (R4)
  task automatic send_ptr(input logic [9:0] p);
    logic a;
    write_byte({DEV, 1'b0}, a); chk("R3 addr ack", 16'(a), 16'd1);
    write_byte({6'b101101, p[9:8]}, a);
    write_byte(p[7:0], a);
  endtask

  task automatic wr_seq(input logic [9:0] p, input int n,
                        input logic [15:0] d0, input logic [15:0] d1, input logic [15:0] d2);
    logic a;
    logic [15:0] d [3];
    d = '{d0, d1, d2};
    i2c_start; send_ptr(p);
    for (int k = 0; k < n; k++) begin
      write_byte(d[k][15:8], a);
      write_byte(d[k][7:0], a);
    end
    i2c_stop;
  endtask

  task automatic rd_seq(input logic set_ptr, input logic [9:0] p, input int n);
    logic a;
    logic [7:0] hi, lo;
    i2c_start;
    if (set_ptr) begin send_ptr(p); i2c_start; end
    write_byte({DEV, 1'b1}, a);
    chk("R2 read addr ack", 16'(a), 16'd1);
    for (int k = 0; k < n; k++) begin
      read_byte(1'b1, hi);
      read_byte(k != n - 1, lo);
      rd_buf[k] = {hi, lo};
    end
    i2c_stop;
  endtask

  initial begin
    logic a, b, low_seen;
    logic [7:0] hb8;
    repeat (4) @(negedge clk);
    chk("R12 reset oe", 16'(sda_oe), 16'd0);
    chk("R5 reset we", 16'(we), 16'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // table: write one register, then set pointer + repeated start + read
    for (int v = 0; v < 6; v++) begin
      wr_seq(VEC[v][25:16], 1, VEC[v][15:0], 16'h0, 16'h0);
      chk("R4 R5 table write", mem[VEC[v][25:16]], VEC[v][15:0]);
      rd_seq(1'b1, VEC[v][25:16], 1);
      chk("R7 R9 table read", rd_buf[0], VEC[v][15:0]);
    end

    // R3 wrong address: no ACK, no write
    i2c_start;
    write_byte({7'b0101111, 1'b0}, a);
    chk("R3 mismatch nack", 16'(a), 16'd0);
    write_byte(8'h00, a); write_byte(8'h00, a);
    write_byte(8'h12, a); write_byte(8'h34, a);
    i2c_stop;
    chk("R3 mismatch no write", mem[0], init_val(0));

    // R5 multi-write with increment, R7 multi-read
    wr_seq(10'h010, 3, 16'h1111, 16'h2222, 16'h3333);
    chk("R5 burst w0", mem[16], 16'h1111);
    chk("R5 burst w1", mem[17], 16'h2222);
    chk("R5 burst w2", mem[18], 16'h3333);
    rd_seq(1'b1, 10'h010, 3);
    chk("R7 burst r0", rd_buf[0], 16'h1111);
    chk("R7 burst r1", rd_buf[1], 16'h2222);
    chk("R7 burst r2", rd_buf[2], 16'h3333);

    // R9 stop clears pointer
    wr_seq(10'h020, 0, 16'h0, 16'h0, 16'h0);
    rd_seq(1'b0, 10'h000, 1);
    chk("R9 ptr cleared by stop", rd_buf[0], init_val(0));

    // R11 odd trailing byte
    i2c_start; send_ptr(10'h030);
    write_byte(8'hBE, a); write_byte(8'hEF, a); write_byte(8'h12, a);
    i2c_stop;
    chk("R11 pair written", mem[48], 16'hBEEF);
    chk("R11 odd byte dropped", mem[49], init_val(49));

    // R6 write saturation, R8 read saturation
    wr_seq(10'h3FE, 3, 16'h5555, 16'h6666, 16'h7777);
    chk("R6 sat 3FE", mem[1022], 16'h5555);
    chk("R6 sat 3FF", mem[1023], 16'h6666);
    chk("R6 no wrap", mem[0], init_val(0));
    rd_seq(1'b1, 10'h3FE, 4);
    chk("R8 rd 3FE", rd_buf[0], 16'h5555);
    chk("R8 rd 3FF", rd_buf[1], 16'h6666);
    chk("R8 rd repeat1", rd_buf[2], 16'h6666);
    chk("R8 rd repeat2", rd_buf[3], 16'h6666);

    // R10 NACK silences the slave
    i2c_start; send_ptr(10'h000); i2c_start;
    write_byte({DEV, 1'b1}, a);
    read_byte(1'b0, hb8);
    chk("R10 first byte", 16'(hb8), 16'(init_val(0) >> 8));
    low_seen = 0;
    for (int i = 0; i < 18; i++) begin
      recv_bit(b);
      if (!b) low_seen = 1;
    end
    chk("R10 silent after nack", 16'(low_seen), 16'd0);
    i2c_stop;

    // R1 stop in mid byte
    i2c_start; send_ptr(10'h040);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    i2c_stop;
    chk("R1 no write on abort", mem[64], init_val(64));
    rd_seq(1'b0, 10'h000, 1);
    chk("R1 idle after mid-byte stop", rd_buf[0], init_val(0));

    chk("R12 oe only while scl low", 16'(r12_viol), 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule